// File: doc/BRIEF.md
# Eight-pin I/O port with peripheral takeover

This block is an eight-pin bidirectional general-purpose port. Software writes an output-data register and a direction register through a small register bus. It reads back those registers and the synchronized level of every pad. For each pad, the block computes the output value, the output enable and the pull-up enable.

Three peripheral enables can claim fixed pins and replace any of the four per-pin controls:

- **Two-wire serial (pins 0 and 1).** The port emulates an open-drain line. The output value is held at zero and the pad is enabled only while the peripheral wants the line low.
- **JTAG (pins 2 to 5).** The port sets pull-ups and directions to suit the test access port, and the digital input path of those pins is disabled.
- **Crystal oscillator (pins 6 and 7).** The port isolates both pins completely.

The serial inputs pass through a cycle-count spike filter before they reach the peripheral. The JTAG pins forward their synchronized levels straight to the test logic.

Top module: `altfn_port`

## Requirements
- R1: After reset, the output-data and direction registers are zero, so every pad has pad_oe=0 and pad_out=0.
- R2: Writes go by wr_sel, with encoding 0=output data, 1=direction, 2=pin readback, 3=unused. Writes to codes 2 and 3 change no register. A read of code 3 returns 0.
- R3: A pin with no active override has pad_out equal to its data bit and pad_oe equal to its direction bit. Its pad_pu is 1 exactly when the direction bit is 0, the data bit is 1 and pullup_off is 0.
- R4: Pin readback (rd_sel=2) shows pad_in through two register stages. A pin whose digital input is disabled reads 0.
- R5: While tw_en=1, pins 0 (serial clock) and 1 (serial data) have pad_out=0. Their pad_oe follows tw_clk_pull and tw_dat_pull respectively. Their pad_pu equals the data bit ANDed with NOT pullup_off, whatever the direction bit.
- R6: While tw_en=1, a change on pad_in[0] or pad_in[1] reaches tw_clk_in or tw_dat_in only after the synchronizer plus FILT_CYC consecutive stable cycles. With the defaults (20 ns clock, 50 ns limit, FILT_CYC=3), a 2-cycle pulse is dropped and a held change appears 5 clock edges after it is driven. While tw_en=0, these outputs follow the synchronizer directly (2 edges).
- R7: While jtag_en=1, pins 2 (TCK), 3 (TMS) and 5 (TDI) have pad_pu=1 and pad_oe=0, and they read back 0.
- R8: While jtag_en=1, pin 4 (TDO) has pad_pu=0 and pad_out=jtag_tdo, and pad_oe=jtag_shift. It reads back 0.
- R9: While osc_en=1, pins 6 and 7 have pad_pu=0 and pad_oe=0, and they read back 0.
- R10: jtag_tck_in, jtag_tms_in and jtag_tdi_in show pad_in[2], pad_in[3] and pad_in[5] after two clock edges, even while their digital input is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target code |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Read source code |
| rd_data | output | 8 | Read data (combinational) |
| pullup_off | input | 1 | Global pull-up disable |
| tw_en | input | 1 | Two-wire serial takeover of pins 0 and 1 |
| tw_clk_pull | input | 1 | Serial peripheral pulls clock line low |
| tw_dat_pull | input | 1 | Serial peripheral pulls data line low |
| jtag_en | input | 1 | JTAG takeover of pins 2 to 5 |
| jtag_shift | input | 1 | TAP is in a shift state |
| jtag_tdo | input | 1 | Test data out value |
| osc_en | input | 1 | Oscillator takeover of pins 6 and 7 |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| pad_pu | output | 8 | Pad pull-up enables |
| tw_clk_in | output | 1 | Filtered serial clock input |
| tw_dat_in | output | 1 | Filtered serial data input |
| jtag_tck_in | output | 1 | Synchronized TCK |
| jtag_tms_in | output | 1 | Synchronized TMS |
| jtag_tdi_in | output | 1 | Synchronized TDI |

## Verification
The assertions check the pad controls on every cycle:

- the open-drain form of the serial pins;
- the forced pull-ups and directions of the JTAG and oscillator pins;
- the plain register path when no enable is set;
- the rule that a filtered serial input moves only on a filter commit.

Only the bench scenarios can show the exact latency of the synchronizer and the filter, the rejection of a short pulse, the masking of disabled inputs in readback, and the ignored register writes.

// File: rtl/altfn_pkg.sv
package altfn_pkg;

  localparam int PORT_W = 8;

  // Fixed pin map: each peripheral owns these positions
  localparam int PIN_SCLK = 0;
  localparam int PIN_SDAT = 1;
  localparam int PIN_TCK  = 2;
  localparam int PIN_TMS  = 3;
  localparam int PIN_TDO  = 4;
  localparam int PIN_TDI  = 5;
  localparam int PIN_XIN  = 6;
  localparam int PIN_XOUT = 7;

  typedef enum logic [1:0] {
    SEL_OUT  = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_PIN  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic tw_en;
    logic tw_clk_pull;
    logic tw_dat_pull;
    logic jtag_en;
    logic jtag_shift;
    logic jtag_tdo;
    logic osc_en;
    logic pullup_off;
  } periph_t;

  // Four enable/value pairs per pin
  typedef struct packed {
    logic pu_en;
    logic pu_val;
    logic dir_en;
    logic dir_val;
    logic val_en;
    logic val_val;
    logic din_en;
    logic din_val;
  } ovr_t;

  function automatic logic default_pull(logic dir, logic data, logic off);
    return !dir && data && !off;
  endfunction

  function automatic ovr_t pin_ovr(int idx, periph_t p, logic data_bit);
    ovr_t o;
    o = '0;
    case (idx)
      PIN_SCLK, PIN_SDAT: begin
        if (p.tw_en) begin
          o.pu_en   = 1'b1;
          o.pu_val  = data_bit && !p.pullup_off;
          o.dir_en  = 1'b1;
          o.dir_val = (idx == PIN_SCLK) ? p.tw_clk_pull : p.tw_dat_pull;
          o.val_en  = 1'b1;
          o.val_val = 1'b0;
        end
      end
      PIN_TCK, PIN_TMS, PIN_TDI: begin
        if (p.jtag_en) begin
          o.pu_en   = 1'b1;
          o.pu_val  = 1'b1;
          o.dir_en  = 1'b1;
          o.dir_val = 1'b0;
          o.din_en  = 1'b1;
          o.din_val = 1'b0;
        end
      end
      PIN_TDO: begin
        if (p.jtag_en) begin
          o.pu_en   = 1'b1;
          o.pu_val  = 1'b0;
          o.dir_en  = 1'b1;
          o.dir_val = p.jtag_shift;
          o.val_en  = 1'b1;
          o.val_val = p.jtag_tdo;
          o.din_en  = 1'b1;
          o.din_val = 1'b0;
        end
      end
      PIN_XIN, PIN_XOUT: begin
        if (p.osc_en) begin
          o.pu_en   = 1'b1;
          o.pu_val  = 1'b0;
          o.dir_en  = 1'b1;
          o.dir_val = 1'b0;
          o.din_en  = 1'b1;
          o.din_val = 1'b0;
        end
      end
      default: o = '0;
    endcase
    return o;
  endfunction

  // Cycles a level must stay stable so that pulses under rej_ps vanish
  function automatic int filt_cycles(int clk_ps, int rej_ps);
    int c;
    c = (rej_ps + clk_ps - 1) / clk_ps;
    if (c < 1) c = 1;
    return c;
  endfunction

endpackage

// File: rtl/altfn_override.sv
module altfn_override
  import altfn_pkg::*;
(
  input  logic [PORT_W-1:0] data_q,
  input  logic [PORT_W-1:0] dir_q,
  input  periph_t           per,
  output logic [PORT_W-1:0] pad_out,
  output logic [PORT_W-1:0] pad_oe,
  output logic [PORT_W-1:0] pad_pu,
  output logic [PORT_W-1:0] din_en
);

  for (genvar g = 0; g < PORT_W; g++) begin : g_pin
    ovr_t o;
    logic base_pu;
    assign o       = pin_ovr(g, per, data_q[g]);
    assign base_pu = default_pull(dir_q[g], data_q[g], per.pullup_off);
    assign pad_pu[g]  = o.pu_en  ? o.pu_val  : base_pu;
    assign pad_oe[g]  = o.dir_en ? o.dir_val : dir_q[g];
    assign pad_out[g] = o.val_en ? o.val_val : data_q[g];
    assign din_en[g]  = o.din_en ? o.din_val : 1'b1;
  end

endmodule

// File: rtl/altfn_sync.sv
module altfn_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end

endmodule

// File: rtl/altfn_glitch.sv
module altfn_glitch #(
  parameter int CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic din,
  output logic dout,
  output logic commit
);

  localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          differ;

  assign differ = din != dout;
  assign commit = en && differ && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout  <= 1'b0;
      cnt_q <= '0;
    end else if (!en) begin
      dout  <= din;
      cnt_q <= '0;
    end else if (!differ) begin
      cnt_q <= '0;
    end else if (commit) begin
      dout  <= din;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/altfn_port.sv
module altfn_port
  import altfn_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 20000,
  parameter int REJECT_PS     = 50000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_sel,
  output logic [7:0] rd_data,
  input  logic       pullup_off,
  input  logic       tw_en,
  input  logic       tw_clk_pull,
  input  logic       tw_dat_pull,
  input  logic       jtag_en,
  input  logic       jtag_shift,
  input  logic       jtag_tdo,
  input  logic       osc_en,
  input  logic [7:0] pad_in,
  output logic [7:0] pad_out,
  output logic [7:0] pad_oe,
  output logic [7:0] pad_pu,
  output logic       tw_clk_in,
  output logic       tw_dat_in,
  output logic       jtag_tck_in,
  output logic       jtag_tms_in,
  output logic       jtag_tdi_in
);

  localparam int FILT_CYC = filt_cycles(CLK_PERIOD_PS, REJECT_PS);
  localparam int N_SER    = 2;

  logic [PORT_W-1:0] data_q, dir_q, din_en, pin_sync;
  logic [N_SER-1:0]  filt_out, filt_commit;
  periph_t           per;

  assign per = '{tw_en: tw_en, tw_clk_pull: tw_clk_pull, tw_dat_pull: tw_dat_pull,
                 jtag_en: jtag_en, jtag_shift: jtag_shift, jtag_tdo: jtag_tdo,
                 osc_en: osc_en, pullup_off: pullup_off};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
    end else if (wr_en) begin
      if (reg_sel_e'(wr_sel) == SEL_OUT) data_q <= wr_data;
      if (reg_sel_e'(wr_sel) == SEL_DIR) dir_q  <= wr_data;
    end
  end

  always_comb begin
    case (reg_sel_e'(rd_sel))
      SEL_OUT: rd_data = data_q;
      SEL_DIR: rd_data = dir_q;
      SEL_PIN: rd_data = pin_sync & din_en;
      default: rd_data = '0;
    endcase
  end

  altfn_override i_ovr (
    .data_q  (data_q),
    .dir_q   (dir_q),
    .per     (per),
    .pad_out (pad_out),
    .pad_oe  (pad_oe),
    .pad_pu  (pad_pu),
    .din_en  (din_en)
  );

  altfn_sync #(.W(PORT_W)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (pin_sync)
  );

  for (genvar s = 0; s < N_SER; s++) begin : g_filt
    altfn_glitch #(.CYC(FILT_CYC)) i_glitch (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (tw_en),
      .din    (pin_sync[s]),
      .dout   (filt_out[s]),
      .commit (filt_commit[s])
    );
  end

  assign tw_clk_in = tw_en ? filt_out[PIN_SCLK] : pin_sync[PIN_SCLK];
  assign tw_dat_in = tw_en ? filt_out[PIN_SDAT] : pin_sync[PIN_SDAT];

  assign jtag_tck_in = pin_sync[PIN_TCK];
  assign jtag_tms_in = pin_sync[PIN_TMS];
  assign jtag_tdi_in = pin_sync[PIN_TDI];

endmodule

// File: rtl/altfn_checker.sv
module altfn_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tw_en,
  input logic       tw_clk_pull,
  input logic       tw_dat_pull,
  input logic       jtag_en,
  input logic       jtag_shift,
  input logic       osc_en,
  input logic [7:0] data_q,
  input logic [7:0] dir_q,
  input logic [7:0] pad_out,
  input logic [7:0] pad_oe,
  input logic [7:0] pad_pu,
  input logic       tw_clk_in,
  input logic       tw_dat_in,
  input logic [1:0] filt_commit
);

  a_r3_plain_pins: assert property (@(posedge clk) disable iff (!rst_n)
    (!tw_en && !jtag_en && !osc_en) |-> (pad_oe == dir_q && pad_out == data_q));

  a_r5_tw_drives_low_only: assert property (@(posedge clk) disable iff (!rst_n)
    tw_en |-> (pad_out[1:0] == 2'b00));

  a_r5_tw_pull_enables: assert property (@(posedge clk) disable iff (!rst_n)
    tw_en |-> (pad_oe[0] == tw_clk_pull && pad_oe[1] == tw_dat_pull));

  a_r6_clk_moves_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (tw_en && $past(tw_en) && tw_clk_in != $past(tw_clk_in)) |-> $past(filt_commit[0]));

  a_r6_dat_moves_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (tw_en && $past(tw_en) && tw_dat_in != $past(tw_dat_in)) |-> $past(filt_commit[1]));

  a_r7_jtag_input_pins: assert property (@(posedge clk) disable iff (!rst_n)
    jtag_en |-> (pad_pu[2] && pad_pu[3] && pad_pu[5] && !pad_oe[2] && !pad_oe[3] && !pad_oe[5]));

  a_r8_tdo_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (jtag_en && !jtag_shift) |-> (!pad_oe[4] && !pad_pu[4]));

  a_r9_osc_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    osc_en |-> (pad_pu[7:6] == 2'b00 && pad_oe[7:6] == 2'b00));

endmodule

bind altfn_port altfn_checker i_altfn_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .tw_en       (tw_en),
  .tw_clk_pull (tw_clk_pull),
  .tw_dat_pull (tw_dat_pull),
  .jtag_en     (jtag_en),
  .jtag_shift  (jtag_shift),
  .osc_en      (osc_en),
  .data_q      (data_q),
  .dir_q       (dir_q),
  .pad_out     (pad_out),
  .pad_oe      (pad_oe),
  .pad_pu      (pad_pu),
  .tw_clk_in   (tw_clk_in),
  .tw_dat_in   (tw_dat_in),
  .filt_commit (filt_commit)
);

// File: tb/test_altfn_port.sv
`timescale 1ns/1ps
module test_altfn_port;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_sel = '0;
  logic [7:0] rd_data;
  logic       pullup_off = 1'b0, tw_en = 1'b0, tw_clk_pull = 1'b0, tw_dat_pull = 1'b0;
  logic       jtag_en = 1'b0, jtag_shift = 1'b0, jtag_tdo = 1'b0, osc_en = 1'b0;
  logic [7:0] pad_in = '0;
  logic [7:0] pad_out, pad_oe, pad_pu;
  logic       tw_clk_in, tw_dat_in, jtag_tck_in, jtag_tms_in, jtag_tdi_in;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam int FILT = (50 + 20 - 1) / 20;

  always #10 clk = ~clk;

  altfn_port i_altfn_port (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .pullup_off(pullup_off), .tw_en(tw_en),
    .tw_clk_pull(tw_clk_pull), .tw_dat_pull(tw_dat_pull), .jtag_en(jtag_en),
    .jtag_shift(jtag_shift), .jtag_tdo(jtag_tdo), .osc_en(osc_en), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .tw_clk_in(tw_clk_in),
    .tw_dat_in(tw_dat_in), .jtag_tck_in(jtag_tck_in), .jtag_tms_in(jtag_tms_in),
    .jtag_tdi_in(jtag_tdi_in)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic write_reg(input logic [1:0] sel, input logic [7:0] val);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = val;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Expected pad controls: {out, oe, pu, input-enable}
  function automatic logic [31:0] model(input logic [7:0] d, input logic [7:0] dir,
                                        input logic off, input logic tw, input logic cp,
                                        input logic dp, input logic je, input logic sh,
                                        input logic tdo, input logic osc);
    logic [7:0] po, poe, ppu, pdi;
    po = d; poe = dir; ppu = ~dir & d & {8{~off}}; pdi = 8'hFF;
    if (tw) begin
      po[1:0] = 2'b00; poe[0] = cp; poe[1] = dp; ppu[1:0] = d[1:0] & {2{~off}};
    end
    if (je) begin
      ppu[5:2] = 4'b1011; poe[5] = 1'b0; poe[4] = sh; poe[3:2] = 2'b00;
      po[4] = tdo; pdi[5:2] = 4'b0000;
    end
    if (osc) begin
      ppu[7:6] = 2'b00; poe[7:6] = 2'b00; pdi[7:6] = 2'b00;
    end
    return {po, poe, ppu, pdi};
  endfunction

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] e;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_sel = 2'd0; #1 check("R1 data reg", rd_data, 8'h00);
    rd_sel = 2'd1; #1 check("R1 dir reg", rd_data, 8'h00);
    check("R1 pad_oe", pad_oe, 8'h00);
    check("R1 pad_out", pad_out, 8'h00);

    // R2 register access and ignored writes
    write_reg(2'd0, 8'h5A);
    write_reg(2'd1, 8'h0F);
    write_reg(2'd2, 8'hFF);
    write_reg(2'd3, 8'hC3);
    rd_sel = 2'd0; #1 check("R2 data reg after ignored writes", rd_data, 8'h5A);
    rd_sel = 2'd1; #1 check("R2 dir reg after ignored writes", rd_data, 8'h0F);
    rd_sel = 2'd3; #1 check("R2 unused code reads zero", rd_data, 8'h00);

    // R3 plain port: pull-up only on inputs with data 1
    check("R3 pad_out", pad_out, 8'h5A);
    check("R3 pad_oe", pad_oe, 8'h0F);
    check("R3 pad_pu", pad_pu, 8'h50);
    @(negedge clk); pullup_off = 1'b1;
    #1 check("R3 pad_pu with global disable", pad_pu, 8'h00);
    pullup_off = 1'b0;

    // R4 readback latency: two edges
    @(negedge clk); pad_in = 8'hA5; rd_sel = 2'd2;
    @(negedge clk); check("R4 one edge: old value", rd_data, 8'h00);
    @(negedge clk); check("R4 two edges: new value", rd_data, 8'hA5);

    // R10 TAP inputs while JTAG disables readback
    jtag_en = 1'b1; pad_in = 8'b0010_1100;
    @(negedge clk); @(negedge clk);
    check("R10 tck/tms/tdi", {5'd0, jtag_tck_in, jtag_tms_in, jtag_tdi_in}, 8'b0000_0111);
    check("R7 R8 jtag pins read zero", rd_data & 8'h3C, 8'h00);
    jtag_en = 1'b0;

    // R6 spike filter on the serial clock pin
    write_reg(2'd1, 8'h00);
    tw_en = 1'b1; pad_in = 8'h00;
    repeat (6) @(negedge clk);
    pad_in[0] = 1'b1;
    @(negedge clk); @(negedge clk);
    pad_in[0] = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check("R6 2-cycle pulse rejected", {7'd0, tw_clk_in}, 8'h00);
    end
    pad_in[0] = 1'b1;
    repeat (2 + FILT - 1) @(negedge clk);
    check("R6 held change not yet passed", {7'd0, tw_clk_in}, 8'h00);
    @(negedge clk);
    check("R6 held change passed", {7'd0, tw_clk_in}, 8'h01);
    tw_en = 1'b0;
    @(negedge clk); pad_in[1] = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R6 bypass while serial off", {7'd0, tw_dat_in}, 8'h01);

    // R8 TDO driven only while shifting
    write_reg(2'd0, 8'h00);
    jtag_en = 1'b1; jtag_tdo = 1'b1; jtag_shift = 1'b1;
    #1 check("R8 TDO oe/out/pu while shifting", {5'd0, pad_oe[4], pad_out[4], pad_pu[4]}, 8'h06);
    jtag_shift = 1'b0;
    #1 check("R8 TDO idle oe", {7'd0, pad_oe[4]}, 8'h00);
    jtag_en = 1'b0; jtag_tdo = 1'b0;

    // R9 oscillator pins isolated, output value untouched
    write_reg(2'd0, 8'hC0);
    write_reg(2'd1, 8'hC0);
    osc_en = 1'b1; pad_in = 8'hC0;
    @(negedge clk); @(negedge clk);
    check("R9 osc pads", {pad_pu[7:6], pad_oe[7:6], pad_out[7:6], 2'b00}, 8'b0000_1100);
    rd_sel = 2'd2; #1 check("R9 osc pins read zero", rd_data & 8'hC0, 8'h00);
    osc_en = 1'b0;

    // Random mix for R3 R4 R5 R7 R8 R9
    for (int it = 0; it < 300; it++) begin
      logic [7:0] d, dir;
      d = 8'($urandom); dir = 8'($urandom);
      @(negedge clk);
      pullup_off = 1'($urandom); tw_en = 1'($urandom); tw_clk_pull = 1'($urandom);
      tw_dat_pull = 1'($urandom); jtag_en = 1'($urandom); jtag_shift = 1'($urandom);
      jtag_tdo = 1'($urandom); osc_en = 1'($urandom); pad_in = 8'($urandom);
      write_reg(2'd0, d);
      write_reg(2'd1, dir);
      rd_sel = 2'd2;
      #1;
      e = model(d, dir, pullup_off, tw_en, tw_clk_pull, tw_dat_pull, jtag_en,
                jtag_shift, jtag_tdo, osc_en);
      check("R3 R5 R8 random pad_out", pad_out, e[31:24]);
      check("R3 R5 R8 random pad_oe", pad_oe, e[23:16]);
      check("R3 R5 R7 R9 random pad_pu", pad_pu, e[15:8]);
      check("R4 R7 R9 random readback", rd_data, pad_in & e[7:0]);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule